// File: doc/BRIEF.md
# Four-Bit ALU Slice with Lookahead Carries and Signed Overflow

This block is a purely combinational arithmetic and logic slice four bits wide. It takes two operands, a carry input and a three-bit operation code, and returns a result word and a carry output. It also returns a block-propagate and block-generate pair, so that an external lookahead unit can form the carry into the next slice without waiting for a ripple. A signed overflow flag comes from comparing sign bits.

Addition and subtraction share one adder. For subtraction, every bit of the second operand passes through an XOR inverter before it reaches the adder. The least significant slice of a chain then forces its incoming carry to one, which completes the two's complement. Higher slices take their carry from the slice below. All internal carries, and the carry output, come from sum-of-products lookahead terms rather than from a ripple chain. The slice has no clock and no stored state, so it carries no valid/ready handshake: its outputs follow its inputs within the same cycle.

Top module: `alu_slice4`

## Requirements
- R1: Operation code 000 adds: result = (A + B + carry_in) mod 16, and carry_out is bit 4 of that sum.
- R2: Operation code 001 subtracts: B is bit-inverted. With IS_LSB=1 the adder carry is forced to 1, giving result = (A - B) mod 16 and carry_out = 1 exactly when A >= B unsigned. With IS_LSB=0 the adder carry is carry_in, giving A + ~B + carry_in.
- R3: Operation codes 010, 011 and 100 give the bitwise AND, OR and XOR of A and B.
- R4: For the three logic operations, carry_out, overflow, blk_prop and blk_gen are all 0, and carry_in has no effect on any output.
- R5: Operation codes 101, 110 and 111 drive every output to 0.
- R6: For add and subtract, overflow is 1 exactly when A bit 3 equals bit 3 of the conditioned B and result bit 3 differs from them. Examples: 0111+0100 gives 1011 with overflow, 1100+1010 gives 0110 with overflow, and 0111+1101 gives 0100 with carry_out 1 and no overflow.
- R7: For add and subtract, blk_prop is 1 exactly when, in every bit position, A or the conditioned B is 1.
- R8: For add and subtract, blk_gen is 1 exactly when the slice would produce a carry with a zero carry into bit 0. carry_out equals blk_gen OR (blk_prop AND adder carry).
- R9: A low slice with IS_LSB=1 and a high slice with IS_LSB=0, joined carry_out to carry_in, form a correct 8-bit adder and subtractor. The overflow flag of the high slice is the 8-bit signed overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code (000 add, 001 sub, 010 AND, 011 OR, 100 XOR) |
| a_in | input | 4 | First operand |
| b_in | input | 4 | Second operand |
| carry_in | input | 1 | Carry from the slice below or from lookahead logic |
| result | output | 4 | Operation result |
| carry_out | output | 1 | Carry out of bit 3 |
| blk_prop | output | 1 | Slice propagates an incoming carry |
| blk_gen | output | 1 | Slice generates a carry by itself |
| overflow | output | 1 | Signed two's-complement overflow |

## Verification
The embedded checks look at every input change. They check that logic and unused codes keep the carry, overflow and block signals low, and that a raised overflow always comes with matching operand signs and a flipped result sign. They also check that the carry output agrees with the block generate and propagate terms, and that a zero code gives a zero result. The actual result values, subtraction with and without the forced carry, the named overflow examples, and the behaviour of two chained slices can only be shown by the bench. It walks every operand, code and carry combination through a behavioural model based on integers.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  typedef enum logic [2:0] {
    OPC_ADD  = 3'b000,
    OPC_SUB  = 3'b001,
    OPC_AND  = 3'b010,
    OPC_OR   = 3'b011,
    OPC_XOR  = 3'b100
  } alu_opc_e;

  function automatic logic opc_is_arith(input logic [2:0] opc);
    return (opc == OPC_ADD) || (opc == OPC_SUB);
  endfunction

  function automatic logic opc_is_logic(input logic [2:0] opc);
    return (opc == OPC_AND) || (opc == OPC_OR) || (opc == OPC_XOR);
  endfunction

endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond
  import alu_slice_pkg::*;
#(
  parameter int W      = 4,
  parameter bit IS_LSB = 1'b1
) (
  input  logic [2:0]   op_sel,
  input  logic [W-1:0] b_raw,
  input  logic         carry_in,
  output logic [W-1:0] b_cond,
  output logic         adder_cin,
  output logic         arith_en
);

  logic inv_en;

  assign inv_en   = (op_sel == OPC_SUB);
  assign arith_en = opc_is_arith(op_sel);

  // one XOR per bit position conditions the second operand
  for (genvar gi = 0; gi < W; gi++) begin : g_xor_cond
    assign b_cond[gi] = b_raw[gi] ^ inv_en;
  end

  generate
    if (IS_LSB) begin : g_lsb_cin
      assign adder_cin = inv_en ? 1'b1 : (arith_en & carry_in);
    end else begin : g_chain_cin
      assign adder_cin = arith_en & carry_in;
    end
  endgenerate

endmodule

// File: rtl/alu_lookahead.sv
module alu_lookahead #(
  parameter int W = 4
) (
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic         c_zero,
  output logic [W-1:0] sum,
  output logic [W:0]   carries,
  output logic         grp_prop,
  output logic         grp_gen
);

  logic [W-1:0] bit_p;
  logic [W-1:0] bit_g;
  logic [W-1:0] bit_h;

  for (genvar gi = 0; gi < W; gi++) begin : g_pgh
    assign bit_p[gi] = x_in[gi] | y_in[gi];
    assign bit_g[gi] = x_in[gi] & y_in[gi];
    assign bit_h[gi] = x_in[gi] ^ y_in[gi];
  end

  // flat sum-of-products for each carry: no term depends on a lower carry
  always_comb begin
    logic term_or;
    logic prod;
    carries    = '0;
    carries[0] = c_zero;
    grp_gen    = 1'b0;
    for (int i = 0; i < W; i++) begin
      term_or = 1'b0;
      for (int j = 0; j <= i; j++) begin
        prod = bit_g[j];
        for (int k = j + 1; k <= i; k++) begin
          prod = prod & bit_p[k];
        end
        term_or = term_or | prod;
      end
      if (i == W - 1) grp_gen = term_or;
      prod = c_zero;
      for (int k = 0; k <= i; k++) begin
        prod = prod & bit_p[k];
      end
      carries[i+1] = term_or | prod;
    end
  end

  assign grp_prop = &bit_p;
  assign sum      = bit_h ^ carries[W-1:0];

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_slice_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [2:0]   op_sel,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] lres
);

  always_comb begin
    unique case (op_sel)
      OPC_AND: lres = a_in & b_in;
      OPC_OR:  lres = a_in | b_in;
      OPC_XOR: lres = a_in ^ b_in;
      default: lres = '0;
    endcase
  end

endmodule

// File: rtl/alu_slice4.sv
module alu_slice4
  import alu_slice_pkg::*;
#(
  parameter int W      = 4,
  parameter bit IS_LSB = 1'b1
) (
  input  logic [2:0]   op_sel,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         blk_prop,
  output logic         blk_gen,
  output logic         overflow
);

  localparam int MSB = W - 1;

  logic [W-1:0] b_cond;
  logic         adder_cin;
  logic         arith_en;
  logic [W-1:0] add_sum;
  logic [W:0]   add_carries;
  logic         la_prop;
  logic         la_gen;
  logic [W-1:0] logic_res;
  logic         sign_agree;

  alu_operand_cond #(.W(W), .IS_LSB(IS_LSB)) u_cond (
    .op_sel    (op_sel),
    .b_raw     (b_in),
    .carry_in  (carry_in),
    .b_cond    (b_cond),
    .adder_cin (adder_cin),
    .arith_en  (arith_en)
  );

  alu_lookahead #(.W(W)) u_cla (
    .x_in     (a_in),
    .y_in     (b_cond),
    .c_zero   (adder_cin),
    .sum      (add_sum),
    .carries  (add_carries),
    .grp_prop (la_prop),
    .grp_gen  (la_gen)
  );

  alu_logic_unit #(.W(W)) u_logic (
    .op_sel (op_sel),
    .a_in   (a_in),
    .b_in   (b_in),
    .lres   (logic_res)
  );

  // signs compared after the XOR conditioning so subtraction is covered
  assign sign_agree = ~(a_in[MSB] ^ b_cond[MSB]);

  assign result    = arith_en ? add_sum : logic_res;
  assign carry_out = arith_en & add_carries[W];
  assign blk_prop  = arith_en & la_prop;
  assign blk_gen   = arith_en & la_gen;
  assign overflow  = arith_en & sign_agree & (add_sum[MSB] ^ a_in[MSB]);

  always_comb begin
    // R4
    logic_quiet_chk: assert (!opc_is_logic(op_sel) ||
                             (!carry_out && !overflow && !blk_prop && !blk_gen));
    // R5
    unused_zero_chk: assert (opc_is_arith(op_sel) || opc_is_logic(op_sel) ||
                             (result == '0 && !carry_out && !overflow));
    // R6
    ovf_sign_chk: assert (!overflow ||
                          ((a_in[MSB] == b_cond[MSB]) && (result[MSB] != a_in[MSB])));
    // R8
    carry_lookahead_chk: assert (!arith_en ||
                                 (carry_out == (blk_gen | (blk_prop & adder_cin))));
    // R1
    add_zero_chk: assert (!(op_sel == OPC_ADD && a_in == '0 && b_in == '0 && !carry_in) ||
                          (result == '0 && !carry_out));
  end

endmodule

// File: tb/alu_slice4_tb.sv
module alu_slice4_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [2:0] op;
  logic [3:0] a_lo, b_lo, a_hi, b_hi;
  logic       cin_lo;
  logic [3:0] r_lo, r_hi;
  logic       co_lo, co_hi, p_lo, p_hi, g_lo, g_hi, v_lo, v_hi;

  int n_chk = 0;
  int n_fail = 0;

  alu_slice4 #(.W(4), .IS_LSB(1'b1)) u_dut (
    .op_sel(op), .a_in(a_lo), .b_in(b_lo), .carry_in(cin_lo),
    .result(r_lo), .carry_out(co_lo), .blk_prop(p_lo), .blk_gen(g_lo), .overflow(v_lo));

  alu_slice4 #(.W(4), .IS_LSB(1'b0)) u_dut_hi (
    .op_sel(op), .a_in(a_hi), .b_in(b_hi), .carry_in(co_lo),
    .result(r_hi), .carry_out(co_hi), .blk_prop(p_hi), .blk_gen(g_hi), .overflow(v_hi));

  typedef struct {
    int res; int co; int p; int g; int v;
  } exp_t;

  function automatic exp_t model(int opc, int a, int b, int cin, int lsb);
    exp_t e;
    int bc, c0, tot, sa, sb, st;
    e.res = 0; e.co = 0; e.p = 0; e.g = 0; e.v = 0;
    if (opc == 0 || opc == 1) begin
      bc  = (opc == 1) ? (15 - b) : b;
      c0  = (opc == 1 && lsb == 1) ? 1 : cin;
      tot = a + bc + c0;
      e.res = tot % 16;
      e.co  = tot / 16;
      sa = (a >= 8) ? a - 16 : a;
      sb = (bc >= 8) ? bc - 16 : bc;
      st = sa + sb + c0;
      e.v = (st > 7 || st < -8) ? 1 : 0;
      e.p = ((a | bc) == 15) ? 1 : 0;
      e.g = (a + bc > 15) ? 1 : 0;
    end else if (opc == 2) e.res = a & b;
    else if (opc == 3) e.res = a | b;
    else if (opc == 4) e.res = a ^ b;
    return e;
  endfunction

  function automatic string req_of(int opc);
    case (opc)
      0: return "R1";
      1: return "R2";
      2, 3, 4: return "R3/R4";
      default: return "R5";
    endcase
  endfunction

  task automatic cmp(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all();
    exp_t el, eh;
    int wa, wb, w, sw;
    el = model(int'(op), int'(a_lo), int'(b_lo), int'(cin_lo), 1);
    eh = model(int'(op), int'(a_hi), int'(b_hi), el.co, 0);
    cmp({req_of(int'(op)), " lo result"}, int'(r_lo), el.res);
    cmp("R1/R2/R4 lo carry_out", int'(co_lo), el.co);
    cmp("R6 lo overflow", int'(v_lo), el.v);
    cmp("R7 lo blk_prop", int'(p_lo), el.p);
    cmp("R8 lo blk_gen", int'(g_lo), el.g);
    cmp({req_of(int'(op)), " hi result"}, int'(r_hi), eh.res);
    cmp("R6 hi overflow", int'(v_hi), eh.v);
    if (op == 3'd0 || op == 3'd1) begin
      // R9: 8-bit view of the chained pair
      wa = int'(a_hi) * 16 + int'(a_lo);
      wb = int'(b_hi) * 16 + int'(b_lo);
      w  = (op == 3'd0) ? (wa + wb + int'(cin_lo)) % 256 : (wa - wb + 256) % 256;
      cmp("R9 chained result", int'(r_hi) * 16 + int'(r_lo), w);
      sw = ((wa >= 128) ? wa - 256 : wa) +
           ((op == 3'd0) ? (((wb >= 128) ? wb - 256 : wb) + int'(cin_lo))
                         : -((wb >= 128) ? wb - 256 : wb));
      cmp("R9 chained overflow", int'(v_hi), (sw > 127 || sw < -128) ? 1 : 0);
    end
  endtask

  task automatic apply(int o, int a, int b, int c, int ah, int bh);
    @(posedge clk);
    #1;
    op = 3'(o); a_lo = 4'(a); b_lo = 4'(b); cin_lo = 1'(c);
    a_hi = 4'(ah); b_hi = 4'(bh);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    op = 3'd0; a_lo = 4'd0; b_lo = 4'd0; cin_lo = 1'b0; a_hi = 4'd0; b_hi = 4'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: all-zero add gives zero outputs
    cmp("R1 reset result", int'(r_lo), 0);
    cmp("R1 reset carry", int'(co_lo), 0);
    rst_n = 1'b1;

    // R6 named examples
    apply(0, 7, 4, 0, 0, 0);
    cmp("R6 7+4 result", int'(r_lo), 11);
    cmp("R6 7+4 overflow", int'(v_lo), 1);
    apply(0, 12, 10, 0, 0, 0);
    cmp("R6 -4+-6 result", int'(r_lo), 6);
    cmp("R6 -4+-6 overflow", int'(v_lo), 1);
    apply(0, 7, 13, 0, 0, 0);
    cmp("R6 7+-3 result", int'(r_lo), 4);
    cmp("R6 7+-3 carry", int'(co_lo), 1);
    cmp("R6 7+-3 overflow", int'(v_lo), 0);
    // R2: -7 minus +1 gives -8 without overflow, carry in ignored on LSB slice
    apply(1, 9, 1, 0, 0, 0);
    cmp("R2 sub result", int'(r_lo), 8);
    cmp("R2 sub carry", int'(co_lo), 1);
    // R4: carry_in has no effect on a logic result
    apply(2, 12, 10, 1, 15, 15);
    cmp("R4 and with carry_in", int'(r_lo), 8);
    cmp("R4 and carry_out", int'(co_lo), 0);

    // exhaustive walk, compared every clock
    for (int o = 0; o < 8; o++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int c = 0; c < 2; c++)
            apply(o, a, b, c, (a * 7 + 3) % 16, (b * 5 + o) % 16);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule